// File: doc/BRIEF.md
# 32-to-16 Bus Width Bridge

This block sits between a memory-mapped master with a 32-bit data path and a memory-mapped slave with a 16-bit data path. The master addresses bytes. The slave addresses halfwords. The bridge turns each single master transfer into one or two slave phases and holds the master in wait until the last phase is done.

Reads and writes are split in different ways. A read always fetches the whole 32-bit word that holds the addressed byte. It does this with two slave reads, the lower halfword first. The master then picks the part it wants from the packed word. A write sends only the halfwords that its byte enables touch. A write to one halfword is therefore one slave write. A write to both halfwords is two slave writes, lower first. Each slave phase waits for the slave's waitrequest to drop. Bursts, caching, arbitration and clock crossing are not handled.

Top module: `bus_halfword_bridge`

## Requirements
- R1: The slave halfword address is the master byte address shifted right by one, with the word-select bits taken from the request. The lowest slave address bit is 0 in the lower-halfword phase and 1 in the upper-halfword phase. Master byte-address bits 1:0 do not change which word is fetched.
- R2: Every master read becomes exactly two slave reads. The lower halfword (slave address bit 0 = 0) is read first and the upper halfword second. Both reads drive slave byte enables 2'b11.
- R3: The read result puts the lower-address halfword in m_rdata[15:0] and the higher-address halfword in m_rdata[31:16]. It is valid in the cycle m_waitreq drops.
- R4: While s_waitreq is high during a slave phase, the bridge holds the slave address, write data, byte enables and command unchanged. Data is transferred correctly under any number of wait states.
- R5: A write whose byte enables touch only bits 3:2 produces a single slave write with slave address bit 0 = 1. In that write, s_byteen equals m_byteen[3:2] and s_wdata equals m_wdata[31:16].
- R6: A write whose byte enables touch only bits 1:0 produces a single slave write with slave address bit 0 = 0. In that write, s_byteen equals m_byteen[1:0] and s_wdata equals m_wdata[15:0].
- R7: A write with byte enables in both halves produces two slave writes, the lower halfword first and then the upper.
- R8: m_waitreq stays high from the request until the last slave phase is accepted, and drops in the next cycle. With a slave that never stalls, this takes 3 cycles for a read or a two-halfword write, 2 for a one-halfword write and 1 for a write with no byte enables.
- R9: After reset, with no request, m_waitreq, s_read and s_write are all low.
- R10: A write with all byte enables clear completes without any slave access.
- R11: s_read and s_write are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_addr | input | MST_AW | Master byte address |
| m_read | input | 1 | Master read request, held until m_waitreq is low |
| m_write | input | 1 | Master write request, held until m_waitreq is low |
| m_byteen | input | 4 | Master byte enables |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Packed read data |
| m_waitreq | output | 1 | Master stall |
| s_addr | output | MST_AW-1 | Slave halfword address |
| s_read | output | 1 | Slave read command |
| s_write | output | 1 | Slave write command |
| s_byteen | output | 2 | Slave byte enables |
| s_wdata | output | 16 | Slave write data |
| s_rdata | input | 16 | Slave read data, valid in the accepting cycle |
| s_waitreq | input | 1 | Slave stall |

## Verification
The hardest case to reach from the ports is a stall that lands on the boundary between the two halves of a read or a two-halfword write. There the lower half has been accepted, but the upper phase is still held by the slave. A wrong bridge would mix old and new address bits or lose the captured lower half at that point. The bench drives a behavioural halfword memory that picks a fresh random wait count for every phase. It then runs many full-word write and read-back pairs, so that stalls of zero to three cycles fall on both phases in all combinations. Directed runs with a slave that never stalls pin down the exact phase order and cycle counts.

// File: rtl/hwb_pkg.sv
// Shared types for the 32-to-16 bus width bridge.
package hwb_pkg;
    // Phase of the slave-side sequence for one master transfer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2,
        PH_DONE = 2'd3
    } phase_e;
endpackage

// File: rtl/hwb_req_latch.sv
// Captures the master request when a transfer starts. It also works out which
// halfword phases the transfer needs. Assumes the master holds its request
// stable while waitrequest is high.
module hwb_req_latch #(
    parameter int WORD_AW = 6,
    parameter int HW      = 16,
    localparam int BEW    = HW / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WORD_AW-1:0]   word_in,
    input  logic                 rd_in,
    input  logic [2*BEW-1:0]     be_in,
    input  logic [2*HW-1:0]      wd_in,
    output logic [WORD_AW-1:0]   word_q,
    output logic                 rd_q,
    output logic [2*BEW-1:0]     be_q,
    output logic [2*HW-1:0]      wd_q,
    output logic                 start_lo,
    output logic                 start_hi,
    output logic                 want_hi
);
    // Holds the request fields for the duration of the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            rd_q   <= 1'b0;
            be_q   <= '0;
            wd_q   <= '0;
        end else if (load) begin
            word_q <= word_in;
            rd_q   <= rd_in;
            be_q   <= be_in;
            wd_q   <= wd_in;
        end
    end

    // Works out the needed phases from the live request (start) and from the latched one (after the lower phase).
    always_comb begin
        start_lo = rd_in | (|be_in[BEW-1:0]);
        start_hi = rd_in | (|be_in[2*BEW-1:BEW]);
        want_hi  = rd_q  | (|be_q[2*BEW-1:BEW]);
    end
endmodule

// File: rtl/hwb_phase_fsm.sv
// Walks through the slave phases of one transfer: lower, then upper, then a
// one-cycle done state in which the master is released. Phases that are not
// needed are skipped.
module hwb_phase_fsm
    import hwb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   start_lo,
    input  logic   start_hi,
    input  logic   want_hi,
    input  logic   s_waitreq,
    output phase_e phase,
    output logic   accept,
    output logic   load
);
    phase_e nxt;

    // Picks the next phase from the request and the slave stall.
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: if (req) nxt = start_lo ? PH_LO : (start_hi ? PH_HI : PH_DONE);
            PH_LO:   if (!s_waitreq) nxt = want_hi ? PH_HI : PH_DONE;
            PH_HI:   if (!s_waitreq) nxt = PH_DONE;
            PH_DONE: nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    // Registers the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    // Flags a slave phase accepted this cycle and the start of a new transfer.
    always_comb begin
        accept = (phase == PH_LO || phase == PH_HI) && !s_waitreq;
        load   = (phase == PH_IDLE) && req;
    end

    // The done state lasts exactly one cycle.
    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_IDLE));
endmodule

// File: rtl/hwb_rd_pack.sv
// Packs the two halfwords of a read into one word. The lower-address halfword
// goes in the low lane. Assumes slave read data is valid in the cycle the
// phase is accepted.
module hwb_rd_pack #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap,
    input  logic            sel_hi,
    input  logic [HW-1:0]   s_rdata,
    output logic [2*HW-1:0] rdata
);
    logic [1:0][HW-1:0] lane;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        // Captures slave data into the lane matching the accepted phase.
        always_ff @(posedge clk) begin
            if (!rst_n)                      lane[g] <= '0;
            else if (cap && (sel_hi == 1'(g))) lane[g] <= s_rdata;
        end
    end

    // Presents the packed word.
    always_comb rdata = lane;
endmodule

// File: rtl/bus_halfword_bridge.sv
// Top of the 32-to-16 bus width bridge. A master read becomes two slave
// halfword reads, lower first. A master write becomes one slave write per
// halfword that has byte enables set. Assumes single transfers only, with the
// master holding its request until waitrequest is low.
module bus_halfword_bridge
    import hwb_pkg::*;
#(
    parameter int MST_AW = 8,
    parameter int HW     = 16,
    localparam int BEW      = HW / 8,
    localparam int LANE_LSB = $clog2(BEW),
    localparam int WORD_LSB = LANE_LSB + 1,
    localparam int WORD_AW  = MST_AW - WORD_LSB,
    localparam int SLV_AW   = MST_AW - LANE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MST_AW-1:0] m_addr,
    input  logic              m_read,
    input  logic              m_write,
    input  logic [2*BEW-1:0]  m_byteen,
    input  logic [2*HW-1:0]   m_wdata,
    output logic [2*HW-1:0]   m_rdata,
    output logic              m_waitreq,
    output logic [SLV_AW-1:0] s_addr,
    output logic              s_read,
    output logic              s_write,
    output logic [BEW-1:0]    s_byteen,
    output logic [HW-1:0]     s_wdata,
    input  logic [HW-1:0]     s_rdata,
    input  logic              s_waitreq
);
    logic               req;
    logic [WORD_AW-1:0] word_q;
    logic               rd_q;
    logic [2*BEW-1:0]   be_q;
    logic [2*HW-1:0]    wd_q;
    logic               start_lo, start_hi, want_hi;
    phase_e             phase;
    logic               accept, load;
    logic               in_phase, sel_hi;

    // Merges the master request strobes.
    always_comb req = m_read | m_write;

    hwb_req_latch #(.WORD_AW(WORD_AW), .HW(HW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .word_in  (m_addr[MST_AW-1:WORD_LSB]),
        .rd_in    (m_read),
        .be_in    (m_byteen),
        .wd_in    (m_wdata),
        .word_q   (word_q),
        .rd_q     (rd_q),
        .be_q     (be_q),
        .wd_q     (wd_q),
        .start_lo (start_lo),
        .start_hi (start_hi),
        .want_hi  (want_hi)
    );

    hwb_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .start_lo  (start_lo),
        .start_hi  (start_hi),
        .want_hi   (want_hi),
        .s_waitreq (s_waitreq),
        .phase     (phase),
        .accept    (accept),
        .load      (load)
    );

    hwb_rd_pack #(.HW(HW)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (accept && rd_q),
        .sel_hi  (sel_hi),
        .s_rdata (s_rdata),
        .rdata   (m_rdata)
    );

    // Drives the slave command for the current halfword phase.
    always_comb begin
        in_phase = (phase == PH_LO) || (phase == PH_HI);
        sel_hi   = (phase == PH_HI);
        s_read   = in_phase && rd_q;
        s_write  = in_phase && !rd_q;
        s_addr   = {word_q, sel_hi, {LANE_LSB{1'b0}}} >> LANE_LSB;
        s_byteen = rd_q ? {BEW{1'b1}} : (sel_hi ? be_q[2*BEW-1:BEW] : be_q[BEW-1:0]);
        s_wdata  = sel_hi ? wd_q[2*HW-1:HW] : wd_q[HW-1:0];
    end

    // Stalls the master until the done state.
    always_comb m_waitreq = req && (phase != PH_DONE);

    // Slave command frozen while stalled.
    assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && s_waitreq) |=>
            ($stable(s_addr) && $stable(s_wdata) && $stable(s_byteen)
             && $stable(s_read) && $stable(s_write)));

    // Never read and write at once.
    assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_read && s_write));

    // Reads use full byte enables.
    assert_read_full_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_read |-> (s_byteen == {BEW{1'b1}}));

    // An accepted lower read is followed by the upper read.
    assert_read_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read && !s_waitreq && !s_addr[0]) |=> (s_read && s_addr[0]));

    // An accepted lower write with upper enables is followed by the upper write.
    assert_write_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_write && !s_waitreq && !s_addr[0] && (|be_q[2*BEW-1:BEW])) |=>
            (s_write && s_addr[0]));

    // The master is released right after the upper phase is accepted.
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && !s_waitreq && s_addr[0]) |=> !m_waitreq);

    // Slave writes always carry some byte enable.
    assert_write_nonzero_be_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_write |-> (s_byteen != '0));
endmodule

// File: tb/bus_halfword_bridge_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module bus_halfword_bridge_tb;
    localparam int MST_AW = 8;
    localparam int SLV_AW = MST_AW - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MST_AW-1:0] m_addr = '0;
    logic              m_read = 1'b0, m_write = 1'b0;
    logic [3:0]        m_byteen = '0;
    logic [31:0]       m_wdata = '0;
    logic [31:0]       m_rdata;
    logic              m_waitreq;
    logic [SLV_AW-1:0] s_addr;
    logic              s_read, s_write;
    logic [1:0]        s_byteen;
    logic [15:0]       s_wdata;
    logic [15:0]       s_rdata = '0;
    logic              s_waitreq = 1'b0;

    bus_halfword_bridge #(.MST_AW(MST_AW)) u_dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0, n_both = 0;

    // Behavioural halfword slave memory with an access log.
    logic [15:0] mem [0:(1<<SLV_AW)-1];
    bit          rand_wait = 0;
    int          cnt = 0;
    bit          armed = 0;
    bit          p_cmd = 0, p_wait = 0, p_wr = 0;
    logic [SLV_AW-1:0] p_addr;
    logic [1:0]  p_be;
    logic [15:0] p_data;
    int          n_log = 0;
    logic [SLV_AW-1:0] lg_addr [0:7];
    bit          lg_wr [0:7];
    logic [1:0]  lg_be [0:7];
    logic [15:0] lg_data [0:7];

    always @(negedge clk) begin
        if (p_cmd && !p_wait) begin
            if (n_log < 8) begin
                lg_addr[n_log] = p_addr; lg_wr[n_log] = p_wr;
                lg_be[n_log] = p_be;     lg_data[n_log] = p_data;
            end
            n_log++;
            if (p_wr) begin
                if (p_be[0]) mem[p_addr][7:0]  = p_data[7:0];
                if (p_be[1]) mem[p_addr][15:8] = p_data[15:8];
            end
            armed = 0;
        end
        if (s_read && s_write) n_both++;
        if (s_read || s_write) begin
            if (!armed) begin
                cnt = rand_wait ? int'($urandom_range(3, 0)) : 0;
                armed = 1;
            end
            s_waitreq = (cnt != 0);
            if (cnt != 0) cnt--;
            s_rdata = mem[s_addr];
        end else begin
            s_waitreq = rand_wait ? 1'($urandom_range(1, 0)) : 1'b0;
            s_rdata = 16'hDEAD;
        end
        p_cmd = s_read || s_write; p_wait = s_waitreq; p_wr = s_write;
        p_addr = s_addr; p_be = s_byteen; p_data = s_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit rd, input logic [7:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rdo, output int cyc);
        @(negedge clk);
        n_log = 0;
        m_addr = addr; m_read = rd; m_write = !rd; m_byteen = be; m_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (m_waitreq && cyc < 64);
        rdo = m_rdata;
        m_read = 0; m_write = 0;
        #1;
    endtask

    task automatic t_reset;
        chk("R9 m_waitreq", 32'(m_waitreq), 0);
        chk("R9 s_read", 32'(s_read), 0);
        chk("R9 s_write", 32'(s_write), 0);
    endtask

    task automatic t_read(input logic [7:0] addr);
        logic [31:0] r; int c; logic [6:0] lo;
        lo = {addr[7:2], 1'b0};
        xfer(1, addr, 4'b0000, 0, r, c);
        chk("R8 read cycles", 32'(c), 3);
        chk("R2 read count", 32'(n_log), 2);
        chk("R1 R2 first addr", 32'(lg_addr[0]), 32'(lo));
        chk("R1 R2 second addr", 32'(lg_addr[1]), 32'(lo | 7'd1));
        chk("R2 read not write", 32'({lg_wr[0], lg_wr[1]}), 0);
        chk("R2 read be", 32'({lg_be[0], lg_be[1]}), 32'h0F);
        chk("R3 packed data", r, {mem[lo | 7'd1], mem[lo]});
    endtask

    task automatic t_write_hi;
        logic [31:0] r; int c; logic [15:0] keep;
        keep = mem[7'h10];
        xfer(0, 8'h22, 4'b1100, 32'hBEEF_1234, r, c);
        chk("R8 single write cycles", 32'(c), 2);
        chk("R5 write count", 32'(n_log), 1);
        chk("R5 addr", 32'(lg_addr[0]), 32'h11);
        chk("R5 be", 32'(lg_be[0]), 32'h3);
        chk("R5 data", 32'(lg_data[0]), 32'hBEEF);
        chk("R5 lower untouched", 32'(mem[7'h10]), 32'(keep));
    endtask

    task automatic t_write_lo;
        logic [31:0] r; int c;
        xfer(0, 8'h30, 4'b0001, 32'h1111_22AB, r, c);
        chk("R6 write count", 32'(n_log), 1);
        chk("R6 addr", 32'(lg_addr[0]), 32'h18);
        chk("R6 be", 32'(lg_be[0]), 32'h1);
        chk("R6 data", 32'(lg_data[0]), 32'h22AB);
    endtask

    task automatic t_write_both;
        logic [31:0] r; int c;
        xfer(0, 8'h40, 4'b1111, 32'hCAFE_F00D, r, c);
        chk("R8 double write cycles", 32'(c), 3);
        chk("R7 write count", 32'(n_log), 2);
        chk("R7 first addr", 32'(lg_addr[0]), 32'h20);
        chk("R7 second addr", 32'(lg_addr[1]), 32'h21);
        chk("R7 order data", {lg_data[1], lg_data[0]}, 32'hCAFE_F00D);
    endtask

    task automatic t_write_none;
        logic [31:0] r; int c;
        xfer(0, 8'h50, 4'b0000, 32'h5555_5555, r, c);
        chk("R10 no slave access", 32'(n_log), 0);
        chk("R8 R10 cycles", 32'(c), 1);
    endtask

    task automatic t_stall_mix;
        logic [31:0] r, d; int c; logic [5:0] w;
        rand_wait = 1;
        for (int i = 0; i < 30; i++) begin
            w = 6'($urandom_range(63, 0));
            d = $urandom;
            xfer(0, {w, 2'b00}, 4'b1111, d, r, c);
            xfer(1, {w, 2'(i)}, 4'b1111, 0, r, c);
            chk("R4 R3 stalled readback", r, d);
            chk("R4 R2 stalled read count", 32'(n_log), 2);
        end
        w = 6'h3A;
        xfer(0, {w, 2'b00}, 4'b1111, 32'h0123_4567, r, c);
        xfer(0, {w, 2'b10}, 4'b1000, 32'hA5FF_FFFF, r, c);
        xfer(1, {w, 2'b00}, 4'b0000, 0, r, c);
        chk("R4 R5 stalled partial write", r, 32'hA523_4567);
        rand_wait = 0;
    endtask

    initial begin
        logic [31:0] r; int c;
        for (int i = 0; i < (1 << SLV_AW); i++) mem[i] = 16'(i * 16'h0101 + 16'h3C00);
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_read(8'h14);
        t_read(8'h16);
        t_write_hi;
        t_write_lo;
        t_write_both;
        t_write_none;
        t_stall_mix;
        xfer(1, 8'h40, 4'b1111, 0, r, c);
        chk("R3 R7 readback", r, 32'hCAFE_F00D);
        chk("R11 no read and write together", 32'(n_both), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule